// File: doc/BRIEF.md
# Self-Routing Omega Switching Network

This block moves up to eight packets at once from eight source lines to eight destination lines through three columns of 2x2 switching elements. Each column has four elements. Before every column, the lines are permuted by a perfect shuffle, which rotates the 3-bit line index left by one bit. Each packet carries a valid bit, a 3-bit destination tag and a payload. Every element looks only at one bit of the destination tags that reach it and sets itself. The first column uses the most significant bit and the last column uses the least significant bit. A 0 sends the packet to the element's upper output and a 1 sends it to the lower output. No central controller computes the settings.

Two packets can meet in one element and ask for the same output. The element then forwards the packet on its upper input and discards the other one. It raises a flag for that element, and it marks the discarded packet's source line as dropped. The block does not retry, queue or arbitrate. The whole network is combinational, and its results are captured in one output register. The results of a set of inputs therefore appear one clock after they are presented.

Top module: `omega_net`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data`, `out_conflict` and `out_dropped` are all zero.
- R2: The outputs at a rising clock edge depend only on the inputs sampled at that same edge, so a result appears exactly one clock after its inputs.
- R3: Before each column the line index is rotated left by one bit. Column s (0 to 2) then routes on destination bit 2-s: a 0 goes to the upper output of the element and a 1 goes to the lower output. A packet that meets no conflict leaves on port `out_valid[dest]` with its payload unchanged in `out_data[dest*8 +: 8]`.
- R4: Element j of column s takes lines 2j (upper) and 2j+1 (lower) after the shuffle. `out_conflict[s*4+j]` is 1 exactly when both of its inputs hold a live packet and the two routing bits are equal. For example, sources 0 and 4 with destinations 4 and 7 collide in element 0 of column 0.
- R5: In a conflict, the packet on the upper input goes on, and the packet on the lower input is discarded. `out_dropped[src]` is set for that packet's source line, so each raised conflict flag matches exactly one dropped source.
- R6: An element with a single live packet routes it by its bit and raises no flag. Inputs whose valid bit is low produce no output valid, no flag and no drop, whatever their destination and payload.
- R7: When all eight inputs are valid and carry distinct destinations, the flags of the last column (`out_conflict[11:8]`) stay zero.
- R8: Every valid input is either delivered to one output port or marked dropped, never both and never neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per source line: packet present |
| in_dest | input | 24 | Per source line: 3-bit destination, line i at [3i +: 3] |
| in_data | input | 64 | Per source line: 8-bit payload, line i at [8i +: 8] |
| out_valid | output | 8 | Per destination port: packet delivered |
| out_data | output | 64 | Per destination port: payload, port p at [8p +: 8] |
| out_conflict | output | 12 | Per element: conflict, index column*4 + element |
| out_dropped | output | 8 | Per source line: packet discarded |

## Verification
The hardest case to reach is a collision that happens only in the middle or last column. That can only happen after the first column has already sorted packets onto shared paths. A last-column collision also needs two packets with the same destination. The stimulus sweeps all 40,320 full permutations, which covers every second-column blocking pattern and shows that the last column never flags. It then adds random sparse masks with repeated destinations, which force collisions in later columns and cases where a packet dropped early leaves a later element with only one packet.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Left rotation of a line index by one bit within lg bits.
  function automatic int unsigned shuffle_idx(input int unsigned idx,
                                              input int unsigned lg);
    int unsigned mask;
    mask = (32'd1 << lg) - 32'd1;
    return ((idx << 1) | (idx >> (lg - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int LG  = 3,
  parameter int DW  = 8,
  parameter int SEL = 2
) (
  input  logic          up_v,
  input  logic [LG-1:0] up_d,
  input  logic [DW-1:0] up_dat,
  input  logic [LG-1:0] up_src,
  input  logic          lo_v,
  input  logic [LG-1:0] lo_d,
  input  logic [DW-1:0] lo_dat,
  input  logic [LG-1:0] lo_src,
  output logic [1:0]    o_v,
  output logic [1:0][LG-1:0] o_d,
  output logic [1:0][DW-1:0] o_dat,
  output logic [1:0][LG-1:0] o_src,
  output logic          conflict,
  output logic          drop_v,
  output logic [LG-1:0] drop_src
);

  logic up_bit;
  logic lo_bit;
  logic clash;

  assign up_bit = up_d[SEL];
  assign lo_bit = lo_d[SEL];
  assign clash  = up_v && lo_v && (up_bit == lo_bit);

  always_comb begin
    o_v      = '0;
    o_d      = '0;
    o_dat    = '0;
    o_src    = '0;
    drop_v   = 1'b0;
    drop_src = '0;
    if (up_v) begin
      o_v[up_bit]   = 1'b1;
      o_d[up_bit]   = up_d;
      o_dat[up_bit] = up_dat;
      o_src[up_bit] = up_src;
    end
    if (lo_v) begin
      if (clash) begin
        drop_v   = 1'b1;
        drop_src = lo_src;
      end else begin
        o_v[lo_bit]   = 1'b1;
        o_d[lo_bit]   = lo_d;
        o_dat[lo_bit] = lo_dat;
        o_src[lo_bit] = lo_src;
      end
    end
  end

  assign conflict = clash;

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int LG  = 3,
  parameter int DW  = 8,
  parameter int SEL = 2
) (
  input  logic [(1<<LG)-1:0]         in_v,
  input  logic [(1<<LG)-1:0][LG-1:0] in_d,
  input  logic [(1<<LG)-1:0][DW-1:0] in_dat,
  input  logic [(1<<LG)-1:0][LG-1:0] in_src,
  output logic [(1<<LG)-1:0]         out_v,
  output logic [(1<<LG)-1:0][LG-1:0] out_d,
  output logic [(1<<LG)-1:0][DW-1:0] out_dat,
  output logic [(1<<LG)-1:0][LG-1:0] out_src,
  output logic [(1<<LG)/2-1:0]       conf,
  output logic [(1<<LG)-1:0]         drop_mask
);

  localparam int N    = 1 << LG;
  localparam int HALF = N / 2;

  logic [N-1:0]         sh_v;
  logic [N-1:0][LG-1:0] sh_d;
  logic [N-1:0][DW-1:0] sh_dat;
  logic [N-1:0][LG-1:0] sh_src;

  logic [HALF-1:0]         sw_drop_v;
  logic [HALF-1:0][LG-1:0] sw_drop_src;

  // Perfect-shuffle link pattern ahead of the switch column.
  for (genvar i = 0; i < N; i++) begin : g_shuffle
    localparam int TGT = int'(omega_pkg::shuffle_idx(i, LG));
    assign sh_v[TGT]   = in_v[i];
    assign sh_d[TGT]   = in_d[i];
    assign sh_dat[TGT] = in_dat[i];
    assign sh_src[TGT] = in_src[i];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_sw
    logic [1:0]         o_v;
    logic [1:0][LG-1:0] o_d;
    logic [1:0][DW-1:0] o_dat;
    logic [1:0][LG-1:0] o_src;

    omega_switch #(.LG(LG), .DW(DW), .SEL(SEL)) u_sw (
      .up_v     (sh_v[2*j]),
      .up_d     (sh_d[2*j]),
      .up_dat   (sh_dat[2*j]),
      .up_src   (sh_src[2*j]),
      .lo_v     (sh_v[2*j+1]),
      .lo_d     (sh_d[2*j+1]),
      .lo_dat   (sh_dat[2*j+1]),
      .lo_src   (sh_src[2*j+1]),
      .o_v      (o_v),
      .o_d      (o_d),
      .o_dat    (o_dat),
      .o_src    (o_src),
      .conflict (conf[j]),
      .drop_v   (sw_drop_v[j]),
      .drop_src (sw_drop_src[j])
    );

    assign out_v[2*j]     = o_v[0];
    assign out_v[2*j+1]   = o_v[1];
    assign out_d[2*j]     = o_d[0];
    assign out_d[2*j+1]   = o_d[1];
    assign out_dat[2*j]   = o_dat[0];
    assign out_dat[2*j+1] = o_dat[1];
    assign out_src[2*j]   = o_src[0];
    assign out_src[2*j+1] = o_src[1];
  end

  always_comb begin
    drop_mask = '0;
    for (int j = 0; j < HALF; j++) begin
      if (sw_drop_v[j]) drop_mask[sw_drop_src[j]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int LG = 3,
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [(1<<LG)-1:0]       in_valid,
  input  logic [(1<<LG)*LG-1:0]    in_dest,
  input  logic [(1<<LG)*DW-1:0]    in_data,
  output logic [(1<<LG)-1:0]       out_valid,
  output logic [(1<<LG)*DW-1:0]    out_data,
  output logic [LG*(1<<LG)/2-1:0]  out_conflict,
  output logic [(1<<LG)-1:0]       out_dropped
);

  localparam int N    = 1 << LG;
  localparam int HALF = N / 2;
  localparam int NSW  = LG * HALF;

  logic [LG:0][N-1:0]         ln_v;
  logic [LG:0][N-1:0][LG-1:0] ln_d;
  logic [LG:0][N-1:0][DW-1:0] ln_dat;
  logic [LG:0][N-1:0][LG-1:0] ln_src;
  logic [LG-1:0][HALF-1:0]    st_conf;
  logic [LG-1:0][N-1:0]       st_drop;

  logic [N-1:0]     nxt_valid;
  logic [N*DW-1:0]  nxt_data;
  logic [NSW-1:0]   nxt_conflict;
  logic [N-1:0]     nxt_dropped;

  // Unpack the source lines; each packet remembers its own source index.
  for (genvar i = 0; i < N; i++) begin : g_in
    assign ln_v[0][i]   = in_valid[i];
    assign ln_d[0][i]   = in_dest[i*LG +: LG];
    assign ln_dat[0][i] = in_data[i*DW +: DW];
    assign ln_src[0][i] = LG'(i);
  end

  // Column s routes on destination bit LG-1-s (most significant first).
  for (genvar s = 0; s < LG; s++) begin : g_col
    omega_stage #(.LG(LG), .DW(DW), .SEL(LG-1-s)) u_stage (
      .in_v      (ln_v[s]),
      .in_d      (ln_d[s]),
      .in_dat    (ln_dat[s]),
      .in_src    (ln_src[s]),
      .out_v     (ln_v[s+1]),
      .out_d     (ln_d[s+1]),
      .out_dat   (ln_dat[s+1]),
      .out_src   (ln_src[s+1]),
      .conf      (st_conf[s]),
      .drop_mask (st_drop[s])
    );
  end

  always_comb begin
    nxt_valid    = ln_v[LG];
    nxt_data     = '0;
    nxt_conflict = '0;
    nxt_dropped  = '0;
    for (int p = 0; p < N; p++) begin
      nxt_data[p*DW +: DW] = ln_dat[LG][p];
    end
    for (int s = 0; s < LG; s++) begin
      nxt_dropped = nxt_dropped | st_drop[s];
      for (int j = 0; j < HALF; j++) begin
        nxt_conflict[s*HALF + j] = st_conf[s][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= '0;
      out_data     <= '0;
      out_conflict <= '0;
      out_dropped  <= '0;
    end else begin
      out_valid    <= nxt_valid;
      out_data     <= nxt_data;
      out_conflict <= nxt_conflict;
      out_dropped  <= nxt_dropped;
    end
  end

  // R8
  conservation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(out_valid) + $countones(out_dropped)
               == $countones($past(in_valid))));

  // R8
  drop_from_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((out_dropped & ~$past(in_valid)) == '0));

  // R5
  drop_per_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_dropped) == $countones(out_conflict));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && in_valid == '0) |=> (out_valid == '0 && out_conflict == '0
                                   && out_dropped == '0));

endmodule

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  in_valid;
  logic [23:0] in_dest;
  logic [63:0] in_data;
  logic [7:0]  out_valid;
  logic [63:0] out_data;
  logic [11:0] out_conflict;
  logic [7:0]  out_dropped;

  int checks;
  int errors;
  int cycles;
  int tag;
  bit done;

  logic [7:0]  exp_valid;
  logic [63:0] exp_data;
  logic [11:0] exp_conf;
  logic [7:0]  exp_drop;

  omega_net uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_dest      (in_dest),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_conflict (out_conflict),
    .out_dropped  (out_dropped)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: each live packet's line is rotated left, then its low bit is
  // replaced by the destination bit of that column.
  task automatic model();
    int  pos [8];
    bit  live [8];
    int  up, lo, bu, bl;
    exp_valid = '0; exp_data = '0; exp_conf = '0; exp_drop = '0;
    for (int k = 0; k < 8; k++) begin
      live[k] = in_valid[k];
      pos[k]  = k;
    end
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++)
        if (live[k]) pos[k] = ((pos[k] << 1) | (pos[k] >> 2)) & 7;
      for (int j = 0; j < 4; j++) begin
        up = -1; lo = -1;
        for (int k = 0; k < 8; k++) begin
          if (live[k] && pos[k] == 2*j)   up = k;
          if (live[k] && pos[k] == 2*j+1) lo = k;
        end
        bu = (up >= 0) ? ((int'(in_dest[up*3 +: 3]) >> (2-s)) & 1) : 0;
        bl = (lo >= 0) ? ((int'(in_dest[lo*3 +: 3]) >> (2-s)) & 1) : 0;
        if (up >= 0 && lo >= 0 && bu == bl) begin
          exp_conf[s*4+j] = 1'b1;
          exp_drop[lo]    = 1'b1;
          live[lo]        = 1'b0;
          pos[up]         = 2*j + bu;
        end else begin
          if (up >= 0) pos[up] = 2*j + bu;
          if (lo >= 0) pos[lo] = 2*j + bl;
        end
      end
    end
    for (int k = 0; k < 8; k++) begin
      if (live[k]) begin
        exp_valid[pos[k]] = 1'b1;
        exp_data[pos[k]*8 +: 8] = in_data[k*8 +: 8];
      end
    end
  endtask

  task automatic apply(input logic [7:0] v, input logic [23:0] d,
                       input bit full_perm);
    @(negedge clk);
    in_valid = v;
    in_dest  = d;
    tag      = tag + 1;
    for (int k = 0; k < 8; k++) in_data[k*8 +: 8] = {3'(k), 5'(tag)};
    model();
    @(negedge clk);
    // R2 R3 R8: delivery one clock later
    check(out_valid == exp_valid, "R3", "out_valid", 64'(out_valid), 64'(exp_valid));
    check((out_data & mask_of(exp_valid)) == exp_data, "R3", "out_data",
          out_data, exp_data);
    // R4 R5 R6: conflict flags
    check(out_conflict == exp_conf, "R4", "out_conflict",
          64'(out_conflict), 64'(exp_conf));
    check(out_dropped == exp_drop, "R5", "out_dropped",
          64'(out_dropped), 64'(exp_drop));
    // R8: no source both delivered and dropped
    check($countones(out_valid) + $countones(out_dropped) == $countones(v),
          "R8", "accounting", 64'($countones(out_valid) + $countones(out_dropped)),
          64'($countones(v)));
    if (full_perm)
      check(out_conflict[11:8] == 4'h0, "R7", "last column flags",
            64'(out_conflict[11:8]), 64'h0);
  endtask

  function automatic logic [63:0] mask_of(input logic [7:0] v);
    logic [63:0] m;
    m = '0;
    for (int p = 0; p < 8; p++) if (v[p]) m[p*8 +: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    int p [8];
    int a, b, t;
    logic [23:0] d;
    checks = 0; errors = 0; cycles = 0; tag = 0; done = 1'b0;
    rst_n = 1'b0;
    in_valid = 8'hFF; in_dest = 24'hFAC688; in_data = '1;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 8'h00 && out_conflict == 12'h000 && out_dropped == 8'h00
          && out_data == 64'h0, "R1", "reset outputs",
          {out_data[39:0], out_valid, out_conflict[7:0], out_dropped},
          64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: input 0 to output 7 alone (exchange in first column)
    apply(8'h01, 24'd7, 1'b0);
    // R4 R5: sources 0 and 4 to destinations 4 and 7 collide in column 0
    apply(8'h11, 24'd4 | (24'd7 << 12), 1'b0);
    check(out_conflict[0] == 1'b1 && out_dropped == 8'h10, "R5",
          "known column-0 block", {52'h0, out_conflict}, 64'h1);
    // R6: idle inputs carry garbage
    apply(8'h00, 24'hFFFFFF, 1'b0);
    // R6: one valid packet from each source to each destination
    for (int s = 0; s < 8; s++)
      for (int q = 0; q < 8; q++)
        apply(8'(1 << s), 24'(q) << (3*s), 1'b0);

    // R3 R7: every full permutation
    for (int k = 0; k < 8; k++) p[k] = k;
    for (int n = 0; n < 40320; n++) begin
      d = '0;
      for (int k = 0; k < 8; k++) d[k*3 +: 3] = 3'(p[k]);
      apply(8'hFF, d, 1'b1);
      a = 6;
      while (a >= 0 && p[a] >= p[a+1]) a--;
      if (a >= 0) begin
        b = 7;
        while (p[b] <= p[a]) b--;
        t = p[a]; p[a] = p[b]; p[b] = t;
        for (int l = a + 1, r = 7; l < r; l++, r--) begin
          t = p[l]; p[l] = p[r]; p[r] = t;
        end
      end
    end

    // R4 R5 R6 R8: random sparse masks with repeated destinations
    for (int n = 0; n < 3000; n++)
      apply(8'($urandom), 24'($urandom), 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule